// File: doc/BRIEF.md
# Line Latch and Polarity Output Sequencer

This block sits between the line-assembly register of a column driver and its per-channel output stages. When the line strobe goes high, it copies the fully assembled line of channel codes into an output latch. On the same edge it captures the polarity input and the output-count mode. The latched codes are then held steady while the next line is being assembled upstream.

Each channel receives its gray-level code and a reference-group bit that picks the upper or lower reference set. Neighbouring channels always sit in opposite groups, and the polarity input swaps which of the two gets the upper set. Channel drive is withheld, which means the output is high-impedance, from the strobe rising edge until a fixed number of clocks after the strobe falling edge. In the reduced-output mode, a contiguous run of channels is marked invalid and is never driven. A strobe that stays high for too few clocks sets an error flag, but its transfer is still performed.

Top module: `line_out_seq`

## Requirements
- R1: After reset, every channel code reads 0, no channel is driven, the error flag is low, all channels are valid, and the reference bits follow polarity 0.
- R2: On the first clock edge that samples the strobe high after it was low, the whole `line_codes_i` bus is copied to `ch_code_o`. Channel k occupies bits [k*CODE_W +: CODE_W], and the copy is visible after that edge.
- R3: That same edge removes drive from every channel, and drive stays off while the strobe is high.
- R4: Take the first edge that samples the strobe low as edge 0. Drive is still off after edge HIZ_CLKS-1 and comes on after edge HIZ_CLKS, with HIZ_CLKS = 4 by default.
- R5: `ch_upper_o[k]` equals 1 (upper group) when k is even and the captured polarity is 0, or when k is odd and the captured polarity is 1. Otherwise it equals 0.
- R6: Polarity and mode are sampled only on the strobe rising edge. Changing them later has no effect on the outputs.
- R7: Changing `line_codes_i` between strobe rising edges has no effect on `ch_code_o`.
- R8: When `narrow_i` is captured as 1, channels GAP_FIRST to GAP_FIRST+GAP_LEN-1 have `ch_valid_o` = 0 and are never driven. When it is captured as 0, every channel is valid.
- R9: If the strobe was sampled high on fewer than MIN_HIGH edges, `short_strobe_o` is set on the falling-edge sample and cleared on the next rising-edge sample. A strobe of MIN_HIGH or more samples leaves the flag clear. The transfer happens either way.
- R10: Once drive is on, it stays on until the next strobe rising edge. A rising edge that lands on the very edge where drive would come on wins, and drive stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Line transfer strobe, sampled on clk |
| pol_i | input | 1 | Polarity, captured on the strobe rising edge |
| narrow_i | input | 1 | 1 selects the reduced-output mode, captured on the strobe rising edge |
| line_codes_i | input | NUM_CH*CODE_W | Assembled line from the data register |
| ch_code_o | output | NUM_CH*CODE_W | Latched per-channel codes |
| ch_upper_o | output | NUM_CH | Per-channel reference group (1 = upper) |
| ch_drive_o | output | NUM_CH | Per-channel drive enable (0 = high-impedance) |
| ch_valid_o | output | NUM_CH | Per-channel valid flag for the captured mode |
| short_strobe_o | output | 1 | Strobe-too-short protocol error |

## Verification
Two functions can fall on the same cycle: the end of the high-impedance countdown and a new strobe rising edge. The bench provokes this by releasing a one-cycle strobe and raising the next one so that the rising edge is sampled on exactly the fourth edge after the falling sample. The scoreboard then expects drive to stay off on every channel, with the new line's codes and polarity already present. The same collision also clears the short-strobe flag set by the previous pulse in that cycle, and the bench checks this too.

// File: rtl/lxs_pkg.sv
package lxs_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_HELD  = 2'd1,
        SEQ_COUNT = 2'd2,
        SEQ_DRIVE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/lxs_strobe_watch.sv
module lxs_strobe_watch #(
    parameter int MIN_HIGH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o,
    output logic fall_o,
    output logic short_o
);
    localparam int CW = $clog2(MIN_HIGH + 1);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_HIGH);
    localparam logic [CW-1:0] ONE_V = CW'(1);

    typedef struct packed {
        logic          strb;
        logic [CW-1:0] hcnt;
        logic          err;
    } watch_t;

    watch_t st_d, st_q;

    assign rise_o  = strobe_i & ~st_q.strb;
    assign fall_o  = ~strobe_i & st_q.strb;
    assign short_o = st_q.err;

    always_comb begin
        st_d      = st_q;
        st_d.strb = strobe_i;
        if (rise_o) begin
            st_d.hcnt = ONE_V;
            st_d.err  = 1'b0;
        end else if (strobe_i && st_q.hcnt < MIN_V) begin
            st_d.hcnt = st_q.hcnt + ONE_V;
        end
        if (fall_o) begin
            st_d.err = (st_q.hcnt < MIN_V);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: the flag can only appear right after a low strobe sample
    p_err_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_o) |-> !$past(strobe_i));
    // R9: a new strobe rise clears the flag
    p_err_clear_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !short_o);
endmodule

// File: rtl/lxs_hiz_timer.sv
module lxs_hiz_timer
    import lxs_pkg::*;
#(
    parameter int HIZ_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic fall_i,
    output logic drive_o
);
    localparam int NW = $clog2(HIZ_CLKS + 1);
    localparam logic [NW-1:0] LOAD_V = NW'(HIZ_CLKS);
    localparam logic [NW-1:0] ONE_V  = NW'(1);

    typedef struct packed {
        seq_state_e    state;
        logic [NW-1:0] cnt;
    } timer_t;

    timer_t tm_d, tm_q;

    assign drive_o = (tm_q.state == SEQ_DRIVE);

    always_comb begin
        tm_d = tm_q;
        if (rise_i) begin
            tm_d.state = SEQ_HELD;
            tm_d.cnt   = '0;
        end else begin
            case (tm_q.state)
                SEQ_HELD: begin
                    if (fall_i) begin
                        tm_d.state = SEQ_COUNT;
                        tm_d.cnt   = LOAD_V;
                    end
                end
                SEQ_COUNT: begin
                    if (tm_q.cnt <= ONE_V) begin
                        tm_d.state = SEQ_DRIVE;
                        tm_d.cnt   = '0;
                    end else begin
                        tm_d.cnt = tm_q.cnt - ONE_V;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q <= '{state: SEQ_IDLE, cnt: '0};
        end else begin
            tm_q <= tm_d;
        end
    end

    // R3: a strobe rise always blanks the outputs
    p_rise_blanks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> !drive_o);
    // R10: drive persists until the next rise
    p_drive_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o && !rise_i) |=> drive_o);
endmodule

// File: rtl/lxs_chan_map.sv
module lxs_chan_map #(
    parameter int NUM_CH    = 24,
    parameter int GAP_FIRST = 12,
    parameter int GAP_LEN   = 3
) (
    input  logic              pol_i,
    input  logic              narrow_i,
    input  logic              drive_i,
    output logic [NUM_CH-1:0] upper_o,
    output logic [NUM_CH-1:0] valid_o,
    output logic [NUM_CH-1:0] en_o
);
    localparam int GAP_END = GAP_FIRST + GAP_LEN;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam bit IN_GAP  = (i >= GAP_FIRST) && (i < GAP_END);
        localparam bit EVEN_CH = ((i % 2) == 0);
        assign valid_o[i] = !(narrow_i && IN_GAP);
        assign upper_o[i] = EVEN_CH ? !pol_i : pol_i;
        assign en_o[i]    = drive_i && valid_o[i];
    end
endmodule

// File: rtl/line_out_seq.sv
module line_out_seq #(
    parameter int NUM_CH    = 24,
    parameter int CODE_W    = 6,
    parameter int HIZ_CLKS  = 4,
    parameter int MIN_HIGH  = 4,
    parameter int GAP_FIRST = 12,
    parameter int GAP_LEN   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe_i,
    input  logic                     pol_i,
    input  logic                     narrow_i,
    input  logic [NUM_CH*CODE_W-1:0] line_codes_i,
    output logic [NUM_CH*CODE_W-1:0] ch_code_o,
    output logic [NUM_CH-1:0]        ch_upper_o,
    output logic [NUM_CH-1:0]        ch_drive_o,
    output logic [NUM_CH-1:0]        ch_valid_o,
    output logic                     short_strobe_o
);
    localparam int BUS_W = NUM_CH * CODE_W;

    typedef struct packed {
        logic [BUS_W-1:0] codes;
        logic             pol;
        logic             narrow;
    } latch_t;

    latch_t lt_d, lt_q;
    logic   rise_w, fall_w, drive_w;

    lxs_strobe_watch #(.MIN_HIGH(MIN_HIGH)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .rise_o   (rise_w),
        .fall_o   (fall_w),
        .short_o  (short_strobe_o)
    );

    lxs_hiz_timer #(.HIZ_CLKS(HIZ_CLKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_w),
        .fall_i  (fall_w),
        .drive_o (drive_w)
    );

    always_comb begin
        lt_d = lt_q;
        if (rise_w) begin
            lt_d.codes  = line_codes_i;
            lt_d.pol    = pol_i;
            lt_d.narrow = narrow_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lt_q <= '0;
        end else begin
            lt_q <= lt_d;
        end
    end

    assign ch_code_o = lt_q.codes;

    lxs_chan_map #(
        .NUM_CH    (NUM_CH),
        .GAP_FIRST (GAP_FIRST),
        .GAP_LEN   (GAP_LEN)
    ) u_map (
        .pol_i    (lt_q.pol),
        .narrow_i (lt_q.narrow),
        .drive_i  (drive_w),
        .upper_o  (ch_upper_o),
        .valid_o  (ch_valid_o),
        .en_o     (ch_drive_o)
    );

    // R7: codes only move on a strobe rise
    p_code_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_w |=> $stable(ch_code_o));
    // R6: reference groups only move on a strobe rise
    p_upper_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_w |=> $stable(ch_upper_o));
    // R4: drive appears only after at least two low strobe samples
    p_drive_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|ch_drive_o) |-> (!$past(strobe_i) && !$past(strobe_i, 2)));
    // R8: an invalid channel is never driven
    p_invalid_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_drive_o & ~ch_valid_o) == '0);
endmodule

// File: tb/line_out_seq_bench.sv
module line_out_seq_bench;
    localparam int NUM_CH    = 24;
    localparam int CODE_W    = 6;
    localparam int HIZ_CLKS  = 4;
    localparam int MIN_HIGH  = 4;
    localparam int GAP_FIRST = 12;
    localparam int GAP_LEN   = 3;
    localparam int BUS_W     = NUM_CH * CODE_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             strobe = 1'b0;
    logic             pol_in = 1'b0;
    logic             narrow_in = 1'b0;
    logic [BUS_W-1:0] line_codes = '0;
    logic [BUS_W-1:0] ch_code;
    logic [NUM_CH-1:0] ch_upper, ch_drive, ch_valid;
    logic             short_flag;

    always #10 clk = ~clk;

    line_out_seq #(
        .NUM_CH(NUM_CH), .CODE_W(CODE_W), .HIZ_CLKS(HIZ_CLKS),
        .MIN_HIGH(MIN_HIGH), .GAP_FIRST(GAP_FIRST), .GAP_LEN(GAP_LEN)
    ) u_line_out_seq (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .pol_i(pol_in),
        .narrow_i(narrow_in), .line_codes_i(line_codes),
        .ch_code_o(ch_code), .ch_upper_o(ch_upper), .ch_drive_o(ch_drive),
        .ch_valid_o(ch_valid), .short_strobe_o(short_flag)
    );

    typedef struct {
        int                cyc;
        string             tag;
        logic [BUS_W-1:0]  codes;
        logic [NUM_CH-1:0] upper;
        logic [NUM_CH-1:0] drive;
        logic [NUM_CH-1:0] valid;
        logic              err;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [BUS_W-1:0] make_codes(input int seed);
        logic [BUS_W-1:0] v;
        for (int i = 0; i < NUM_CH; i++) begin
            v[i*CODE_W +: CODE_W] = CODE_W'(seed * 7 + i * 13 + seed * i);
        end
        return v;
    endfunction

    function automatic logic [NUM_CH-1:0] exp_upper(input logic p);
        logic [NUM_CH-1:0] v;
        for (int i = 0; i < NUM_CH; i++) v[i] = ((i % 2) == 0) ? !p : p;
        return v;
    endfunction

    function automatic logic [NUM_CH-1:0] exp_valid(input logic nar);
        logic [NUM_CH-1:0] v;
        for (int i = 0; i < NUM_CH; i++)
            v[i] = !(nar && i >= GAP_FIRST && i < GAP_FIRST + GAP_LEN);
        return v;
    endfunction

    // monitor: pops expectations when their cycle comes up
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            bit bad;
            cur = sb.pop_front();
            bad = 1'b0;
            n_vec++;
            if (cur.cyc != cyc) begin
                $display("FAIL %s: expectation for cycle %0d seen at %0d", cur.tag, cur.cyc, cyc);
                bad = 1'b1;
            end
            if (ch_code !== cur.codes) begin
                $display("FAIL %s codes @%0d: got %h exp %h", cur.tag, cyc, ch_code, cur.codes);
                bad = 1'b1;
            end
            if (ch_upper !== cur.upper) begin
                $display("FAIL %s upper @%0d: got %b exp %b", cur.tag, cyc, ch_upper, cur.upper);
                bad = 1'b1;
            end
            if (ch_drive !== cur.drive) begin
                $display("FAIL %s drive @%0d: got %b exp %b", cur.tag, cyc, ch_drive, cur.drive);
                bad = 1'b1;
            end
            if (ch_valid !== cur.valid) begin
                $display("FAIL %s valid @%0d: got %b exp %b", cur.tag, cyc, ch_valid, cur.valid);
                bad = 1'b1;
            end
            if (short_flag !== cur.err) begin
                $display("FAIL %s short flag @%0d: got %b exp %b", cur.tag, cyc, short_flag, cur.err);
                bad = 1'b1;
            end
            if (bad) n_bad++;
        end
    end

    // driver: one line transfer, pushes what each stage must show
    task automatic run_line(input int seed, input logic p, input logic nar,
                            input int hi_n, input int settle, input string tag);
        logic [BUS_W-1:0] codes;
        exp_t e;
        int   c0, f;
        codes = make_codes(seed);
        @(posedge clk); #2;
        line_codes = codes; pol_in = p; narrow_in = nar; strobe = 1'b1;
        c0 = cyc;
        f  = c0 + hi_n + 1;
        e.codes = codes; e.upper = exp_upper(p); e.valid = exp_valid(nar);
        e.drive = '0; e.err = 1'b0;
        e.cyc = c0 + 1;      e.tag = {tag, " R2 R3 R5 R8 R9 R10 rise"}; sb.push_back(e);
        e.cyc = c0 + hi_n;   e.tag = {tag, " R3 R10 held high"};        sb.push_back(e);
        e.err = (hi_n < MIN_HIGH);
        e.cyc = f + HIZ_CLKS - 1; e.tag = {tag, " R4 R9 hiz window"};   sb.push_back(e);
        if (settle >= HIZ_CLKS) begin
            e.cyc = f + HIZ_CLKS; e.drive = exp_valid(nar);
            e.tag = {tag, " R4 R6 R7 R8 drive on"};
            sb.push_back(e);
        end
        for (int k = 0; k < hi_n; k++) begin
            @(posedge clk); #2;
            if (k == 0) begin
                line_codes = ~codes; pol_in = ~p; narrow_in = ~nar;
            end
            if (k == hi_n - 1) strobe = 1'b0;
        end
        repeat (settle) begin
            @(posedge clk); #2;
        end
    endtask

    initial begin
        exp_t e;
        int   r;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        r = cyc;
        e.cyc = r + 1; e.tag = "R1 reset"; e.codes = '0; e.upper = exp_upper(1'b0);
        e.drive = '0; e.valid = exp_valid(1'b0); e.err = 1'b0;
        sb.push_back(e);
        repeat (3) @(posedge clk);
        run_line(1, 1'b0, 1'b0, 4, 6, "full pol0");
        run_line(2, 1'b1, 1'b0, 6, 5, "full pol1 long");
        run_line(3, 1'b0, 1'b1, 4, 5, "narrow pol0");
        run_line(4, 1'b1, 1'b0, 2, 5, "short strobe");
        run_line(5, 1'b0, 1'b0, 1, 3, "one-cycle strobe");
        run_line(6, 1'b1, 1'b0, 4, 5, "collision rise");
        run_line(7, 1'b1, 1'b1, 5, 4, "narrow pol1");
        run_line(8, 1'b0, 1'b0, 3, 6, "back to full");
        repeat (10) @(posedge clk);
        if (sb.size() != 0) begin
            $display("FAIL scoreboard R2: %0d expectations never checked, expected 0", sb.size());
            n_bad++;
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1: run still active after 20000 cycles, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule